// File: doc/BRIEF.md
# System error reporting aggregator

The block gathers error event strobes from the memory path, the primary bus and the graphics port of a host bridge and folds them into a single active-low system-error line. Each input is a one-cycle strobe from a detector outside the block: an ECC decoder, a parity checker, an address-range comparator or a bus master watching for target aborts.

A master enable gates every source. Each source also has its own enable bit. While memory initialization runs, ECC strobes are dropped. Any qualified event in a cycle pulls the output low for the following clock only, so several events in one cycle give one pulse, and events on consecutive clocks give one unbroken low stretch. A sticky status vector records which enabled source fired. Software clears a status bit by writing a 1 to it.

Top module: `serr_agg`

Source index map, used by `src_en_i`, `evt_i`, `clr_i` and `status_o`:

| Bit | Source |
|---|---|
| 0 | correctable ECC error |
| 1 | uncorrectable ECC error |
| 2 | target abort on a bridge-initiated primary-bus cycle |
| 3 | target abort on a bridge-initiated graphics-port cycle |
| 4 | primary-bus address or data parity error |
| 5 | graphics-port address or data parity error |
| 6 | invalid translation-table entry access |
| 7 | graphics-master access outside the aperture |
| 8 | graphics-master access outside both the aperture and valid DRAM |

## Requirements
- R1: After reset, serr_no is 1 and status_o is all zeros.
- R2: While glb_en_i is 0, no event drives serr_no low and no status bit is set.
- R3: An event on bit k (source map above) has an effect only when src_en_i[k] is 1. A disabled source changes neither serr_no nor status_o.
- R4: While init_busy_i is 1, events on bits 0 and 1 (ECC) are ignored. Events on bits 2 to 8 still take effect.
- R5: A qualified event sampled at clock edge N drives serr_no to 0 from edge N until edge N+1. serr_no returns to 1 when no qualified event is present at edge N+1.
- R6: Several qualified events in the same cycle produce a single one-clock low pulse.
- R7: Qualified events on consecutive clocks hold serr_no at 0 continuously, with no high cycle between them.
- R8: A qualified event on bit k sets status_o[k] at the same edge. The bit holds until a cycle with clr_i[k]=1, and clearing one bit leaves the other bits unchanged.
- R9: When status bit k is set and cleared in the same cycle, the set wins and status_o[k] reads 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| glb_en_i | input | 1 | Master system-error enable |
| src_en_i | input | 9 | Enable bit for each source |
| init_busy_i | input | 1 | Memory initialization in progress |
| evt_i | input | 9 | One-cycle event strobe for each source |
| clr_i | input | 9 | Write-1-to-clear strobe for each status bit |
| serr_no | output | 1 | System error, active low |
| status_o | output | 9 | Sticky record of enabled sources that fired |

## Verification
The hardest case to reach is a set and a clear that land on the same status bit in the same clock, together with a back-to-back event burst that must not show a high glitch. Directed tests hold the clear strobe and an event strobe across one shared edge. They then drive strobes on two adjacent edges and sample serr_no at both following half-cycles. A vector table covers the gating combinations: master enable off, source masked, and initialization with ECC-only or mixed events.

// File: rtl/serr_pkg.sv
package serr_pkg;
  localparam int SRC_COUNT = 9;
  localparam int SRC_ECC_CE = 0;
  localparam int SRC_ECC_UE = 1;
  localparam int SRC_PRI_TABORT = 2;
  localparam int SRC_GFX_TABORT = 3;
  localparam int SRC_PRI_PERR = 4;
  localparam int SRC_GFX_PERR = 5;
  localparam int SRC_XLAT_INVAL = 6;
  localparam int SRC_OUT_APER = 7;
  localparam int SRC_OUT_MEM = 8;
  localparam logic [SRC_COUNT-1:0] ECC_SRC_MASK =
    (SRC_COUNT'(1) << SRC_ECC_CE) | (SRC_COUNT'(1) << SRC_ECC_UE);
endpackage

// File: rtl/serr_qual.sv
module serr_qual #(
  parameter int N_SRC = serr_pkg::SRC_COUNT,
  parameter logic [N_SRC-1:0] INIT_BLOCK_MASK = serr_pkg::ECC_SRC_MASK
) (
  input  logic             glb_en_i,
  input  logic [N_SRC-1:0] src_en_i,
  input  logic             init_busy_i,
  input  logic [N_SRC-1:0] evt_i,
  output logic [N_SRC-1:0] hit_o
);
  for (genvar k = 0; k < N_SRC; k++) begin : g_src
    logic blocked;
    if (INIT_BLOCK_MASK[k]) begin : g_init_gated
      assign blocked = init_busy_i;
    end else begin : g_free
      assign blocked = 1'b0;
    end
    assign hit_o[k] = evt_i[k] & src_en_i[k] & glb_en_i & ~blocked;
  end
endmodule

// File: rtl/serr_status.sv
module serr_status #(
  parameter int N_SRC = serr_pkg::SRC_COUNT
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [N_SRC-1:0] set_i,
  input  logic [N_SRC-1:0] clr_i,
  output logic [N_SRC-1:0] status_o
);
  logic [N_SRC-1:0] status_q;
  // set has priority over clear
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) status_q <= '0;
    else         status_q <= (status_q & ~clr_i) | set_i;
  end
  assign status_o = status_q;
endmodule

// File: rtl/serr_drive.sv
module serr_drive #(
  parameter int N_SRC = serr_pkg::SRC_COUNT
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [N_SRC-1:0] hit_i,
  output logic             serr_no
);
  logic serr_q;
  // one low cycle per cycle carrying any hit
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) serr_q <= 1'b1;
    else         serr_q <= ~(|hit_i);
  end
  assign serr_no = serr_q;
endmodule

// File: rtl/serr_agg.sv
module serr_agg #(
  parameter int N_SRC = serr_pkg::SRC_COUNT
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             glb_en_i,
  input  logic [N_SRC-1:0] src_en_i,
  input  logic             init_busy_i,
  input  logic [N_SRC-1:0] evt_i,
  input  logic [N_SRC-1:0] clr_i,
  output logic             serr_no,
  output logic [N_SRC-1:0] status_o
);
  localparam logic [N_SRC-1:0] INIT_MASK = N_SRC'(serr_pkg::ECC_SRC_MASK);

  logic [N_SRC-1:0] hit;

  serr_qual #(.N_SRC(N_SRC), .INIT_BLOCK_MASK(INIT_MASK)) qual_i (
    .glb_en_i    (glb_en_i),
    .src_en_i    (src_en_i),
    .init_busy_i (init_busy_i),
    .evt_i       (evt_i),
    .hit_o       (hit)
  );

  serr_status #(.N_SRC(N_SRC)) status_i (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .set_i    (hit),
    .clr_i    (clr_i),
    .status_o (status_o)
  );

  serr_drive #(.N_SRC(N_SRC)) drive_i (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .hit_i   (hit),
    .serr_no (serr_no)
  );
endmodule

module serr_agg_chk #(
  parameter int N_SRC = serr_pkg::SRC_COUNT
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic             glb_en_i,
  input logic [N_SRC-1:0] src_en_i,
  input logic             init_busy_i,
  input logic [N_SRC-1:0] evt_i,
  input logic [N_SRC-1:0] clr_i,
  input logic             serr_no,
  input logic [N_SRC-1:0] status_o
);
  localparam logic [N_SRC-1:0] ECC_M = N_SRC'(serr_pkg::ECC_SRC_MASK);

  // R2
  glb_gate_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !glb_en_i |=> serr_no);

  // R3
  src_mask_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ((evt_i & src_en_i) == '0) |=> serr_no);

  // R4
  init_ecc_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (init_busy_i && ((evt_i & ~ECC_M) == '0)) |=> serr_no);

  // R5
  pulse_end_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (evt_i == '0) |=> serr_no);

  // R8
  sticky_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ((status_o & ~clr_i) != '0) |=>
      ((status_o & $past(status_o & ~clr_i)) == $past(status_o & ~clr_i)));

  // R9
  set_wins_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (glb_en_i && !init_busy_i && ((evt_i & src_en_i & clr_i) != '0)) |=>
      (status_o != '0));
endmodule

bind serr_agg serr_agg_chk #(.N_SRC(N_SRC)) chk_i (.*);

// File: tb/serr_agg_tb_top.sv
module serr_agg_tb_top;
  localparam int N = 9;
  localparam logic [N-1:0] ALL = '1;

  typedef struct packed {
    logic         glb;
    logic [N-1:0] en;
    logic         init;
    logic [N-1:0] evt;
    logic         exp_n;
    logic [N-1:0] exp_st;
  } vec_t;

  // ECC ce=bit0 ue=bit1, pri tabort=2, gfx tabort=3, perr 4/5, xlat 6, aper 7/8
  localparam int NV = 13;
  localparam vec_t VECS [NV] = '{
    '{1'b1, 9'h1FF, 1'b0, 9'h001, 1'b0, 9'h001},
    '{1'b1, 9'h1FF, 1'b0, 9'h002, 1'b0, 9'h002},
    '{1'b1, 9'h1FF, 1'b0, 9'h004, 1'b0, 9'h004},
    '{1'b1, 9'h1FF, 1'b0, 9'h008, 1'b0, 9'h008},
    '{1'b1, 9'h1FF, 1'b0, 9'h030, 1'b0, 9'h030},
    '{1'b1, 9'h1FF, 1'b0, 9'h1C0, 1'b0, 9'h1C0},
    '{1'b0, 9'h1FF, 1'b0, 9'h1FF, 1'b1, 9'h000},
    '{1'b1, 9'h1FE, 1'b0, 9'h001, 1'b1, 9'h000},
    '{1'b1, 9'h0FF, 1'b0, 9'h100, 1'b1, 9'h000},
    '{1'b1, 9'h1FF, 1'b1, 9'h003, 1'b1, 9'h000},
    '{1'b1, 9'h1FF, 1'b1, 9'h007, 1'b0, 9'h004},
    '{1'b1, 9'h1FF, 1'b0, 9'h1FF, 1'b0, 9'h1FF},
    '{1'b1, 9'h0AA, 1'b0, 9'h1FF, 1'b0, 9'h0AA}
  };

  logic clk_i = 1'b0;
  logic rst_ni = 1'b0;
  logic glb_en_i = 1'b0;
  logic [N-1:0] src_en_i = '0;
  logic init_busy_i = 1'b0;
  logic [N-1:0] evt_i = '0;
  logic [N-1:0] clr_i = '0;
  logic serr_no;
  logic [N-1:0] status_o;

  int n_run = 0;
  int n_fail = 0;
  bit done = 1'b0;

  always #4 clk_i = ~clk_i;

  serr_agg #(.N_SRC(N)) dut_i (.*);

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s act=%0h exp=%0h", req, act, exp);
    end
  endtask

  task automatic clear_all();
    @(negedge clk_i);
    evt_i = '0; clr_i = ALL;
    @(negedge clk_i);
    clr_i = '0;
  endtask

  initial begin
    repeat (3) @(negedge clk_i);
    chk("R1 serr", 32'(serr_no), 32'd1);
    chk("R1 status", 32'(status_o), 32'd0);
    rst_ni = 1'b1;
    @(negedge clk_i);

    for (int i = 0; i < NV; i++) begin
      clear_all();
      glb_en_i = VECS[i].glb; src_en_i = VECS[i].en;
      init_busy_i = VECS[i].init; evt_i = VECS[i].evt;
      @(negedge clk_i);
      chk($sformatf("R2/R3/R4/R6 vec%0d serr", i), 32'(serr_no), 32'(VECS[i].exp_n));
      chk($sformatf("R8 vec%0d status", i), 32'(status_o), 32'(VECS[i].exp_st));
      evt_i = '0; init_busy_i = 1'b0;
      @(negedge clk_i);
      chk($sformatf("R5 vec%0d release", i), 32'(serr_no), 32'd1);
    end

    // R7: back to back
    clear_all();
    glb_en_i = 1'b1; src_en_i = ALL;
    evt_i = 9'h010;
    @(negedge clk_i);
    chk("R7 first", 32'(serr_no), 32'd0);
    evt_i = 9'h040;
    #2 chk("R7 mid", 32'(serr_no), 32'd0);
    @(negedge clk_i);
    chk("R7 second", 32'(serr_no), 32'd0);
    evt_i = '0;
    @(negedge clk_i);
    chk("R7 end", 32'(serr_no), 32'd1);
    chk("R8 both set", 32'(status_o), 32'h050);

    // R8: clear one bit only, others held
    clr_i = 9'h010;
    @(negedge clk_i);
    clr_i = '0;
    chk("R8 partial clear", 32'(status_o), 32'h040);
    repeat (3) @(negedge clk_i);
    chk("R8 hold", 32'(status_o), 32'h040);

    // R9: set and clear same cycle
    evt_i = 9'h040; clr_i = 9'h040;
    @(negedge clk_i);
    evt_i = '0; clr_i = '0;
    chk("R9 set wins", 32'(status_o), 32'h040);

    // R3: disabled source leaves held status untouched
    src_en_i = 9'h000; evt_i = 9'h1BF;
    @(negedge clk_i);
    evt_i = '0;
    chk("R3 masked serr", 32'(serr_no), 32'd1);
    chk("R3 masked status", 32'(status_o), 32'h040);

    // R1: reset mid-run
    rst_ni = 1'b0;
    @(negedge clk_i);
    chk("R1 re-reset status", 32'(status_o), 32'd0);
    chk("R1 re-reset serr", 32'(serr_no), 32'd1);
    done = 1'b1;
  end

  initial begin
    fork
      wait (done);
      begin
        repeat (5000) @(posedge clk_i);
        n_run++; n_fail++;
        $display("FAIL watchdog act=timeout exp=done");
      end
    join_any
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule